// File: doc/BRIEF.md
# Double-Buffered Polyphase Coefficient Store

This block holds the filter coefficients of a polyphase scaler in two banks. One bank is active and feeds the filter datapath through a registered read port. The other bank is the shadow that a host fills. A load begins with a start command that names the filter type and its tap count. A stream of data words follows, and each word carries one even and one odd tap coefficient. The write pointer walks through the tap pairs of a phase first and then moves to the next phase. Only the first half of the phase range plus the centre phase is stored. Reads of the upper phases are folded back onto the stored phases by symmetry, with the tap order reversed.

A swap request does not change the bank at once. It is held until the next frame-start strobe, so a frame never uses coefficients from both banks. At that strobe the active bank flips and a chroma-coefficient mode bit is latched. When both the luma and the chroma tap counts of one direction are exactly two, the direction uses fixed two-tap coefficients. Loads for that direction's filter types are then refused, and a sharpening enable is derived for the direction.

Top module: `coef_dbuf_ram`

## Requirements
- R1: After reset, `active_bank`=0, `chroma_mode`=0, `swap_armed`=0 and `load_busy`=0. Every read returns zero on both taps.
- R2: Data words write only the bank that was inactive when the load started. Reads of the active bank are unchanged until a swap takes effect.
- R3: A swap request takes effect at the next `frame_start` strobe, or at a strobe in the same cycle as the request. The active bank then flips exactly once, however many requests were made. Without a strobe the active bank never changes.
- R4: A start command with type code 0..5 and tap count 1..8 clears the write pointer to pair 0, phase 0. The type codes are 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical and 5 alpha horizontal. The load takes 33 phases × ceil(taps/2) words, with pairs stepping before phases. `load_busy` is high from the cycle after the start until the cycle after the last word. Words that arrive outside a load are ignored, and a start with an out-of-range type or tap count is refused.
- R5: When the odd tap index 2·pair+1 of a word is at or beyond the tap count, the stored odd coefficient is zero, whatever the word carries.
- R6: Bits 1:0 of every stored coefficient are zero.
- R7: `rd_even`/`rd_odd` appear one clock after the request. Phases 0..32 return taps 2·pair and 2·pair+1. A phase p in 33..63 returns taps taps−1−2·pair and taps−2−2·pair of phase 64−p. Any tap index below 0, or at or above 2·ceil(taps/2), reads as zero.
- R8: The even half and the odd half of a word are written only when their own enable bit is set. A cleared enable leaves the earlier contents of that half in place (subject to R5).
- R9: `h_fixed2` is high exactly when both horizontal tap counts equal 2, and `v_fixed2` likewise for the vertical counts. While a direction's flag is high, a start for one of its types is refused, and a refused start leaves `load_busy` low. Odd type codes are horizontal and even type codes are vertical.
- R10: `h_sharp_on` = `h_fixed2` and a non-zero horizontal sharpness factor, and the same holds for the vertical direction.
- R11: `chroma_mode` takes the value of `swap_chroma` from the latest swap request at the moment that request takes effect.
- R12: A swap that takes effect during a load ends the load, so that `load_busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Start a coefficient load |
| ld_type | input | 3 | Filter type code of the load |
| ld_taps | input | 4 | Tap count of the load |
| ld_word_vld | input | 1 | Data word valid |
| ld_even | input | 14 | Even tap coefficient |
| ld_even_en | input | 1 | Write enable of the even half |
| ld_odd | input | 14 | Odd tap coefficient |
| ld_odd_en | input | 1 | Write enable of the odd half |
| load_busy | output | 1 | A load is in progress |
| swap_req | input | 1 | Request a bank swap |
| swap_chroma | input | 1 | Chroma mode to apply with the swap |
| frame_start | input | 1 | Frame-start strobe |
| active_bank | output | 1 | Bank currently read by the datapath |
| chroma_mode | output | 1 | Latched chroma-coefficient mode |
| swap_armed | output | 1 | A swap waits for a frame start |
| h_taps_y | input | 4 | Horizontal luma tap count |
| h_taps_c | input | 4 | Horizontal chroma tap count |
| v_taps_y | input | 4 | Vertical luma tap count |
| v_taps_c | input | 4 | Vertical chroma tap count |
| h_sharp | input | 4 | Horizontal sharpness factor |
| v_sharp | input | 4 | Vertical sharpness factor |
| h_fixed2 | output | 1 | Horizontal fixed two-tap mode |
| v_fixed2 | output | 1 | Vertical fixed two-tap mode |
| h_sharp_on | output | 1 | Horizontal two-tap sharpening enable |
| v_sharp_on | output | 1 | Vertical two-tap sharpening enable |
| rd_type | input | 3 | Read filter type |
| rd_phase | input | 6 | Read phase, 0..63 |
| rd_pair | input | 2 | Read tap pair index |
| rd_even | output | 14 | Even tap of the read pair |
| rd_odd | output | 14 | Odd tap of the read pair |

## Verification
The hardest case to reach is the mirrored read of an odd tap count. Here the two output taps come from two different stored pairs, and one of them falls below tap index 0. The case is only visible after a complete load and a swap at a frame strobe. The bench therefore loads every tap count from 1 to 8 in turn, swaps each load in, and sweeps all 64 phases and all four pair indices against an arithmetic model of the fold. The write-enable case needs the same bank written twice with an unrelated load in the other bank in between. The bench gets there with three loads and swaps in sequence.

// File: rtl/coef_dbuf_pkg.sv
package coef_dbuf_pkg;

  // Filter type codes; the low bit marks the horizontal direction.
  typedef enum logic [2:0] {
    FT_Y_VERT = 3'd0,
    FT_Y_HORZ = 3'd1,
    FT_C_VERT = 3'd2,
    FT_C_HORZ = 3'd3,
    FT_A_VERT = 3'd4,
    FT_A_HORZ = 3'd5
  } filt_type_e;

  function automatic bit type_is_horz(input int sel);
    return (sel % 2) == 1;
  endfunction

  function automatic int pairs_of(input int taps);
    return (taps + 1) / 2;
  endfunction

  // Stored phase that a requested phase folds onto.
  function automatic int fold_phase(input int ph, input int n_phases);
    return (ph <= n_phases / 2) ? ph : n_phases - ph;
  endfunction

  // Tap index served on a slot (0 even, 1 odd) for a pair, after folding.
  function automatic int fold_tap(input int ph, input int n_phases,
                                  input int taps, input int pair, input int slot);
    if (ph <= n_phases / 2) return 2 * pair + slot;
    return taps - 1 - 2 * pair - slot;
  endfunction

endpackage

// File: rtl/coef_wr_ptr.sv
module coef_wr_ptr #(
  parameter int STORED_PH = 33,
  parameter int MAX_TAPS  = 8,
  parameter int TYPE_W    = 3,
  parameter int TAP_W     = 4,
  parameter int SPH_W     = 6,
  parameter int PR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_ok,
  input  logic [TYPE_W-1:0] start_type,
  input  logic [TAP_W-1:0]  start_taps,
  input  logic              start_bank,
  input  logic              abort,
  input  logic              word_vld,
  output logic              busy,
  output logic [SPH_W-1:0]  ptr_phase,
  output logic [PR_W-1:0]   ptr_pair,
  output logic [TYPE_W-1:0] cur_type,
  output logic [TAP_W-1:0]  cur_taps,
  output logic              cur_bank,
  output logic [TAP_W-1:0]  n_pairs,
  output logic              wr_en,
  output logic              last_word
);

  logic pair_wrap;

  always_comb begin
    n_pairs   = (cur_taps + TAP_W'(1)) >> 1;
    wr_en     = busy && word_vld && !start && !abort;
    pair_wrap = (TAP_W'(ptr_pair) == n_pairs - TAP_W'(1));
    last_word = wr_en && pair_wrap && (ptr_phase == SPH_W'(STORED_PH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ptr_phase <= '0;
      ptr_pair  <= '0;
      cur_type  <= '0;
      cur_taps  <= '0;
      cur_bank  <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy      <= start_ok;
      ptr_phase <= '0;
      ptr_pair  <= '0;
      cur_type  <= start_type;
      cur_taps  <= start_taps;
      cur_bank  <= start_bank;
    end else if (wr_en) begin
      if (pair_wrap) begin
        ptr_pair  <= '0;
        ptr_phase <= ptr_phase + SPH_W'(1);
        if (last_word) busy <= 1'b0;
      end else begin
        ptr_pair <= ptr_pair + PR_W'(1);
      end
    end
  end

endmodule

// File: rtl/coef_bank_ctl.sv
module coef_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic swap_chroma,
  input  logic frame_start,
  output logic active_bank,
  output logic chroma_mode,
  output logic swap_armed,
  output logic swap_fire
);

  logic held_chroma;
  logic next_chroma;

  always_comb begin
    swap_fire   = frame_start && (swap_armed || swap_req);
    next_chroma = swap_req ? swap_chroma : held_chroma;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_bank <= 1'b0;
      chroma_mode <= 1'b0;
      swap_armed  <= 1'b0;
      held_chroma <= 1'b0;
    end else if (swap_fire) begin
      active_bank <= ~active_bank;
      chroma_mode <= next_chroma;
      swap_armed  <= 1'b0;
    end else if (swap_req) begin
      swap_armed  <= 1'b1;
      held_chroma <= swap_chroma;
    end
  end

endmodule

// File: rtl/tap2_mode.sv
module tap2_mode #(
  parameter int TAP_W   = 4,
  parameter int SHARP_W = 4
) (
  input  logic [TAP_W-1:0]   h_taps_y,
  input  logic [TAP_W-1:0]   h_taps_c,
  input  logic [TAP_W-1:0]   v_taps_y,
  input  logic [TAP_W-1:0]   v_taps_c,
  input  logic [SHARP_W-1:0] h_sharp,
  input  logic [SHARP_W-1:0] v_sharp,
  output logic               h_fixed2,
  output logic               v_fixed2,
  output logic               h_sharp_on,
  output logic               v_sharp_on
);

  logic [TAP_W-1:0]   ty [2];
  logic [TAP_W-1:0]   tc [2];
  logic [SHARP_W-1:0] sf [2];
  logic [1:0]         fx;
  logic [1:0]         sh;

  assign ty[0] = h_taps_y;
  assign tc[0] = h_taps_c;
  assign sf[0] = h_sharp;
  assign ty[1] = v_taps_y;
  assign tc[1] = v_taps_c;
  assign sf[1] = v_sharp;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign fx[d] = (ty[d] == TAP_W'(2)) && (tc[d] == TAP_W'(2));
    assign sh[d] = fx[d] && (sf[d] != '0);
  end

  assign h_fixed2   = fx[0];
  assign v_fixed2   = fx[1];
  assign h_sharp_on = sh[0];
  assign v_sharp_on = sh[1];

endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 8,
  parameter int COEF_W     = 14,
  parameter int NUM_TYPES  = 6,
  parameter int TYPE_W     = 3,
  parameter int TAP_W      = 4,
  parameter int PH_W       = 6,
  parameter int SPH_W      = 6,
  parameter int PR_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tab_set,
  input  logic              tab_bank,
  input  logic [TYPE_W-1:0] tab_type,
  input  logic [TAP_W-1:0]  tab_taps,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [TYPE_W-1:0] wr_type,
  input  logic [SPH_W-1:0]  wr_phase,
  input  logic [PR_W-1:0]   wr_pair,
  input  logic [TAP_W-1:0]  wr_taps,
  input  logic [COEF_W-1:0] even_data,
  input  logic              even_en,
  input  logic [COEF_W-1:0] odd_data,
  input  logic              odd_en,
  input  logic              rd_bank,
  input  logic [TYPE_W-1:0] rd_type,
  input  logic [PH_W-1:0]   rd_phase,
  input  logic [PR_W-1:0]   rd_pair,
  output logic [COEF_W-1:0] rd_even,
  output logic [COEF_W-1:0] rd_odd
);
  import coef_dbuf_pkg::*;

  localparam int STORED_PH = NUM_PHASES / 2 + 1;
  localparam int MAX_PAIRS = (MAX_TAPS + 1) / 2;
  localparam int N_TAB     = 2 * NUM_TYPES;
  localparam int DEPTH     = N_TAB * STORED_PH * MAX_PAIRS;
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int TAB_W     = $clog2(N_TAB);

  logic [COEF_W-1:0] mem_e [DEPTH];
  logic [COEF_W-1:0] mem_o [DEPTH];
  logic [TAP_W-1:0]  tap_tab [N_TAB];

  function automatic int slot_addr(input int bank, input int typ,
                                   input int ph, input int pair);
    return ((bank * NUM_TYPES + typ) * STORED_PH + ph) * MAX_PAIRS + pair;
  endfunction

  function automatic logic [COEF_W-1:0] clear_lsbs(input logic [COEF_W-1:0] d);
    return {d[COEF_W-1:2], 2'b00};
  endfunction

  // Write side
  logic [ADDR_W-1:0] wa;
  logic              odd_past_end;

  always_comb begin
    wa = ADDR_W'(slot_addr(int'(wr_bank), int'(wr_type), int'(wr_phase), int'(wr_pair)));
    odd_past_end = (2 * int'(wr_pair) + 1) >= int'(wr_taps);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (even_en) mem_e[wa] <= clear_lsbs(even_data);
      if (odd_past_end) mem_o[wa] <= '0;
      else if (odd_en) mem_o[wa] <= clear_lsbs(odd_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_TAB; i++) tap_tab[i] <= '0;
    end else if (tab_set) begin
      tap_tab[TAB_W'(int'(tab_bank) * NUM_TYPES + int'(tab_type))] <= tab_taps;
    end
  end

  // Read side: fold the phase, pick the two source taps, gate out-of-range taps.
  int                rd_tc;
  int                rd_sp;
  int                rd_te;
  int                rd_to;
  int                rd_lim;
  logic [COEF_W-1:0] e_val;
  logic [COEF_W-1:0] o_val;
  logic [ADDR_W-1:0] ae;
  logic [ADDR_W-1:0] ao;

  always_comb begin
    if (int'(rd_type) < NUM_TYPES)
      rd_tc = int'(tap_tab[TAB_W'(int'(rd_bank) * NUM_TYPES + int'(rd_type))]);
    else
      rd_tc = 0;
    rd_lim = 2 * pairs_of(rd_tc);
    rd_sp  = fold_phase(int'(rd_phase), NUM_PHASES);
    rd_te  = fold_tap(int'(rd_phase), NUM_PHASES, rd_tc, int'(rd_pair), 0);
    rd_to  = fold_tap(int'(rd_phase), NUM_PHASES, rd_tc, int'(rd_pair), 1);
    ae = '0;
    ao = '0;
    e_val = '0;
    o_val = '0;
    if (rd_te >= 0 && rd_te < rd_lim) begin
      ae = ADDR_W'(slot_addr(int'(rd_bank), int'(rd_type), rd_sp, rd_te / 2));
      e_val = (rd_te % 2 == 0) ? mem_e[ae] : mem_o[ae];
    end
    if (rd_to >= 0 && rd_to < rd_lim) begin
      ao = ADDR_W'(slot_addr(int'(rd_bank), int'(rd_type), rd_sp, rd_to / 2));
      o_val = (rd_to % 2 == 0) ? mem_e[ao] : mem_o[ao];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_even <= '0;
      rd_odd  <= '0;
    end else begin
      rd_even <= e_val;
      rd_odd  <= o_val;
    end
  end

endmodule

// File: rtl/coef_dbuf_ram.sv
module coef_dbuf_ram #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 8,
  parameter int COEF_W     = 14,
  parameter int NUM_TYPES  = 6,
  parameter int SHARP_W    = 4,
  localparam int TYPE_W    = $clog2(NUM_TYPES),
  localparam int TAP_W     = $clog2(MAX_TAPS + 1),
  localparam int PH_W      = $clog2(NUM_PHASES),
  localparam int PR_W      = $clog2((MAX_TAPS + 1) / 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_start,
  input  logic [TYPE_W-1:0]  ld_type,
  input  logic [TAP_W-1:0]   ld_taps,
  input  logic               ld_word_vld,
  input  logic [COEF_W-1:0]  ld_even,
  input  logic               ld_even_en,
  input  logic [COEF_W-1:0]  ld_odd,
  input  logic               ld_odd_en,
  output logic               load_busy,
  input  logic               swap_req,
  input  logic               swap_chroma,
  input  logic               frame_start,
  output logic               active_bank,
  output logic               chroma_mode,
  output logic               swap_armed,
  input  logic [TAP_W-1:0]   h_taps_y,
  input  logic [TAP_W-1:0]   h_taps_c,
  input  logic [TAP_W-1:0]   v_taps_y,
  input  logic [TAP_W-1:0]   v_taps_c,
  input  logic [SHARP_W-1:0] h_sharp,
  input  logic [SHARP_W-1:0] v_sharp,
  output logic               h_fixed2,
  output logic               v_fixed2,
  output logic               h_sharp_on,
  output logic               v_sharp_on,
  input  logic [TYPE_W-1:0]  rd_type,
  input  logic [PH_W-1:0]    rd_phase,
  input  logic [PR_W-1:0]    rd_pair,
  output logic [COEF_W-1:0]  rd_even,
  output logic [COEF_W-1:0]  rd_odd
);
  import coef_dbuf_pkg::*;

  localparam int STORED_PH = NUM_PHASES / 2 + 1;
  localparam int SPH_W     = $clog2(STORED_PH);

  // Named internal events, also watched by the bound checker.
  logic              start_ok;
  logic              start_acc;
  logic              swap_fire;
  logic              wr_en;
  logic              wr_bank;
  logic              last_word;
  logic [SPH_W-1:0]  ptr_phase;
  logic [PR_W-1:0]   ptr_pair;
  logic [TYPE_W-1:0] cur_type;
  logic [TAP_W-1:0]  cur_taps;
  logic [TAP_W-1:0]  n_pairs;
  logic              dir_fixed;

  tap2_mode #(.TAP_W(TAP_W), .SHARP_W(SHARP_W)) u_tap2 (
    .h_taps_y  (h_taps_y),
    .h_taps_c  (h_taps_c),
    .v_taps_y  (v_taps_y),
    .v_taps_c  (v_taps_c),
    .h_sharp   (h_sharp),
    .v_sharp   (v_sharp),
    .h_fixed2  (h_fixed2),
    .v_fixed2  (v_fixed2),
    .h_sharp_on(h_sharp_on),
    .v_sharp_on(v_sharp_on)
  );

  always_comb begin
    dir_fixed = type_is_horz(int'(ld_type)) ? h_fixed2 : v_fixed2;
    start_ok  = (int'(ld_type) < NUM_TYPES) && (ld_taps != '0) &&
                (int'(ld_taps) <= MAX_TAPS) && !dir_fixed;
    start_acc = ld_start && start_ok && !swap_fire;
  end

  coef_bank_ctl u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_req   (swap_req),
    .swap_chroma(swap_chroma),
    .frame_start(frame_start),
    .active_bank(active_bank),
    .chroma_mode(chroma_mode),
    .swap_armed (swap_armed),
    .swap_fire  (swap_fire)
  );

  coef_wr_ptr #(
    .STORED_PH(STORED_PH), .MAX_TAPS(MAX_TAPS), .TYPE_W(TYPE_W),
    .TAP_W(TAP_W), .SPH_W(SPH_W), .PR_W(PR_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ld_start),
    .start_ok  (start_ok),
    .start_type(ld_type),
    .start_taps(ld_taps),
    .start_bank(~active_bank),
    .abort     (swap_fire),
    .word_vld  (ld_word_vld),
    .busy      (load_busy),
    .ptr_phase (ptr_phase),
    .ptr_pair  (ptr_pair),
    .cur_type  (cur_type),
    .cur_taps  (cur_taps),
    .cur_bank  (wr_bank),
    .n_pairs   (n_pairs),
    .wr_en     (wr_en),
    .last_word (last_word)
  );

  coef_store #(
    .NUM_PHASES(NUM_PHASES), .MAX_TAPS(MAX_TAPS), .COEF_W(COEF_W),
    .NUM_TYPES(NUM_TYPES), .TYPE_W(TYPE_W), .TAP_W(TAP_W),
    .PH_W(PH_W), .SPH_W(SPH_W), .PR_W(PR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .tab_set  (start_acc),
    .tab_bank (~active_bank),
    .tab_type (ld_type),
    .tab_taps (ld_taps),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_type  (cur_type),
    .wr_phase (ptr_phase),
    .wr_pair  (ptr_pair),
    .wr_taps  (cur_taps),
    .even_data(ld_even),
    .even_en  (ld_even_en),
    .odd_data (ld_odd),
    .odd_en   (ld_odd_en),
    .rd_bank  (active_bank),
    .rd_type  (rd_type),
    .rd_phase (rd_phase),
    .rd_pair  (rd_pair),
    .rd_even  (rd_even),
    .rd_odd   (rd_odd)
  );

endmodule

// File: rtl/coef_dbuf_ram_chk.sv
module coef_dbuf_ram_chk #(
  parameter int STORED_PH = 33,
  parameter int SPH_W     = 6,
  parameter int PR_W      = 2,
  parameter int TAP_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             swap_req,
  input logic             swap_armed,
  input logic             active_bank,
  input logic             load_busy,
  input logic             ld_start,
  input logic             start_ok,
  input logic             wr_en,
  input logic             wr_bank,
  input logic             last_word,
  input logic [SPH_W-1:0] ptr_phase,
  input logic [PR_W-1:0]  ptr_pair,
  input logic [TAP_W-1:0] n_pairs,
  input logic             h_fixed2,
  input logic             v_fixed2,
  input logic             h_sharp_on,
  input logic             v_sharp_on
);

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_bank));

  p_bank_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (swap_armed || swap_req)) |=> (active_bank != $past(active_bank)));

  p_wr_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != active_bank));

  p_load_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !load_busy);

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> ((int'(ptr_phase) < STORED_PH) && (TAP_W'(ptr_pair) < n_pairs)));

  p_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_start && !start_ok) |=> !load_busy);

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (swap_armed || swap_req)) |=> !load_busy);

  p_h_sharp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_sharp_on |-> h_fixed2);

  p_v_sharp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    v_sharp_on |-> v_fixed2);

endmodule

bind coef_dbuf_ram coef_dbuf_ram_chk #(
  .STORED_PH(STORED_PH), .SPH_W(SPH_W), .PR_W(PR_W), .TAP_W(TAP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .swap_req   (swap_req),
  .swap_armed (swap_armed),
  .active_bank(active_bank),
  .load_busy  (load_busy),
  .ld_start   (ld_start),
  .start_ok   (start_ok),
  .wr_en      (wr_en),
  .wr_bank    (wr_bank),
  .last_word  (last_word),
  .ptr_phase  (ptr_phase),
  .ptr_pair   (ptr_pair),
  .n_pairs    (n_pairs),
  .h_fixed2   (h_fixed2),
  .v_fixed2   (v_fixed2),
  .h_sharp_on (h_sharp_on),
  .v_sharp_on (v_sharp_on)
);

// File: tb/coef_dbuf_ram_bench.sv
`timescale 1ns/1ps
module coef_dbuf_ram_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_start = 0, ld_word_vld = 0, ld_even_en = 1, ld_odd_en = 1;
  logic [2:0]  ld_type = 0;
  logic [3:0]  ld_taps = 0;
  logic [13:0] ld_even = 0, ld_odd = 0;
  logic        swap_req = 0, swap_chroma = 0, frame_start = 0;
  logic [3:0]  h_taps_y = 4, h_taps_c = 4, v_taps_y = 4, v_taps_c = 4;
  logic [3:0]  h_sharp = 3, v_sharp = 0;
  logic [2:0]  rd_type = 0;
  logic [5:0]  rd_phase = 0;
  logic [1:0]  rd_pair = 0;
  logic        load_busy, active_bank, chroma_mode, swap_armed;
  logic        h_fixed2, v_fixed2, h_sharp_on, v_sharp_on;
  logic [13:0] rd_even, rd_odd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  coef_dbuf_ram u_coef_dbuf_ram (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raw value the bench sends for a tap; the stored value has bits 1:0 cleared.
  function automatic int raw_val(int seed, int typ, int ph, int t);
    return (seed * 977 + typ * 4099 + ph * 131 + t * 29 + 7) % 16384;
  endfunction

  function automatic int slot_val(int seed, int typ, int ph, int t, int taps);
    int np = (taps + 1) / 2;
    if (t < 0 || t >= 2 * np) return 0;
    if (t >= taps) return 0;
    return raw_val(seed, typ, ph, t) & 16380;
  endfunction

  task automatic load(input int typ, input int taps, input int seed,
                      input bit e_en, input bit o_en);
    @(negedge clk);
    ld_start = 1; ld_type = 3'(typ); ld_taps = 4'(taps);
    @(negedge clk);
    ld_start = 0;
    ld_even_en = e_en; ld_odd_en = o_en;
    for (int ph = 0; ph < 33; ph++) begin
      for (int pr = 0; pr < (taps + 1) / 2; pr++) begin
        ld_word_vld = 1;
        ld_even = 14'(raw_val(seed, typ, ph, 2 * pr));
        ld_odd  = 14'(raw_val(seed, typ, ph, 2 * pr + 1));
        @(negedge clk);
      end
    end
    ld_word_vld = 0;
    ld_even_en = 1; ld_odd_en = 1;
  endtask

  task automatic do_swap(input bit chroma);
    @(negedge clk);
    swap_req = 1; swap_chroma = chroma;
    @(negedge clk);
    swap_req = 0;
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic read_at(input int typ, input int ph, input int pr,
                         output int ev, output int od);
    rd_type = 3'(typ); rd_phase = 6'(ph); rd_pair = 2'(pr);
    @(negedge clk);
    ev = int'(rd_even); od = int'(rd_odd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int ev, od, bank0, sp, te, tor;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 active_bank", active_bank, 0);
    check("R1 chroma_mode", chroma_mode, 0);
    check("R1 swap_armed", swap_armed, 0);
    check("R1 load_busy", load_busy, 0);
    read_at(0, 5, 1, ev, od);
    check("R1 read even", ev, 0);
    check("R1 read odd", od, 0);
    // R10 / R9 with non-two tap counts
    check("R9 h_fixed2 off", h_fixed2, 0);
    check("R10 h_sharp_on off", h_sharp_on, 0);

    // Sweep every tap count through load, swap and full read
    for (int n = 1; n <= 8; n++) begin
      int typ = n % 6;
      bank0 = active_bank;
      @(negedge clk);
      ld_start = 1; ld_type = 3'(typ); ld_taps = 4'(n);
      @(negedge clk);
      ld_start = 0;
      check("R4 busy after start", load_busy, 1);
      for (int ph = 0; ph < 33; ph++) begin
        for (int pr = 0; pr < (n + 1) / 2; pr++) begin
          ld_word_vld = 1;
          ld_even = 14'(raw_val(n, typ, ph, 2 * pr));
          ld_odd  = 14'(raw_val(n, typ, ph, 2 * pr + 1));
          @(negedge clk);
        end
      end
      ld_word_vld = 0;
      check("R4 busy after last word", load_busy, 0);
      // stray word outside a load must be ignored
      ld_word_vld = 1; ld_even = 14'h3fff; ld_odd = 14'h3fff;
      @(negedge clk);
      ld_word_vld = 0;
      if (n == 1) begin
        read_at(typ, 0, 0, ev, od);
        check("R2 active bank untouched", ev, 0);
      end
      swap_req = 1; swap_chroma = n[0];
      @(negedge clk);
      swap_req = 0;
      repeat (2) @(negedge clk);
      check("R3 armed before frame", swap_armed, 1);
      check("R3 bank held before frame", active_bank, bank0);
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
      check("R3 bank flipped", active_bank, 1 - bank0);
      check("R11 chroma latched", chroma_mode, n % 2);
      for (int ph = 0; ph < 64; ph++) begin
        for (int pr = 0; pr < 4; pr++) begin
          read_at(typ, ph, pr, ev, od);
          if (ph <= 32) begin
            sp = ph; te = 2 * pr; tor = te + 1;
          end else begin
            sp = 64 - ph; te = n - 1 - 2 * pr; tor = te - 1;
          end
          check(ph <= 32 ? "R4 direct even" : "R7 mirror even", ev, slot_val(n, typ, sp, te, n));
          check(ph <= 32 ? "R5 direct odd" : "R7 mirror odd", od, slot_val(n, typ, sp, tor, n));
          check("R6 low bits", (ev | od) & 3, 0);
        end
      end
    end

    // R5 explicit: 3 taps, pair 1 odd slot (tap 3) reads zero although a value was sent
    load(0, 3, 9, 1, 1);
    do_swap(0);
    read_at(0, 4, 1, ev, od);
    check("R5 odd past count", od, 0);
    check("R6 even low bits", ev, raw_val(9, 0, 4, 2) & 16380);

    // R8 write enables across three loads of the same bank pair
    load(2, 4, 21, 1, 1);
    do_swap(0);
    bank0 = active_bank;
    load(2, 4, 22, 1, 1);
    do_swap(0);
    load(2, 4, 23, 0, 1);
    do_swap(0);
    check("R8 same bank back", active_bank, bank0);
    read_at(2, 5, 1, ev, od);
    check("R8 even kept", ev, raw_val(21, 2, 5, 2) & 16380);
    check("R8 odd rewritten", od, raw_val(23, 2, 5, 3) & 16380);

    // R9 / R10 fixed two-tap direction
    @(negedge clk);
    h_taps_y = 2; h_taps_c = 2;
    #1;
    check("R9 h_fixed2 on", h_fixed2, 1);
    check("R9 v_fixed2 off", v_fixed2, 0);
    check("R10 h_sharp_on", h_sharp_on, 1);
    check("R10 v_sharp_on", v_sharp_on, 0);
    h_sharp = 0;
    #1;
    check("R10 zero factor", h_sharp_on, 0);
    @(negedge clk);
    ld_start = 1; ld_type = 3'd1; ld_taps = 4'd2;
    @(negedge clk);
    ld_start = 0;
    check("R9 horizontal start refused", load_busy, 0);
    ld_start = 1; ld_type = 3'd0; ld_taps = 4'd9;
    @(negedge clk);
    ld_start = 0;
    check("R4 bad tap count refused", load_busy, 0);
    h_taps_c = 3;
    #1;
    check("R9 mixed counts", h_fixed2, 0);

    // R12 swap during a load ends it
    ld_start = 1; ld_type = 3'd4; ld_taps = 4'd4;
    @(negedge clk);
    ld_start = 0;
    ld_word_vld = 1;
    repeat (3) @(negedge clk);
    ld_word_vld = 0;
    check("R12 busy mid load", load_busy, 1);
    bank0 = active_bank;
    swap_req = 1; frame_start = 1; swap_chroma = 1;
    @(negedge clk);
    swap_req = 0; frame_start = 0;
    check("R12 load ended", load_busy, 0);
    check("R3 same-cycle swap", active_bank, 1 - bank0);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    check("R3 no second flip", active_bank, 1 - bank0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule